// File: doc/BRIEF.md
# Time-of-Day Counter for Packet Timestamping

This block keeps the running wall-clock time used to stamp frames on the transmit and receive paths. The time has three parts: a 48-bit count of seconds, a 32-bit count of nanoseconds and a 16-bit fraction of a nanosecond. On every clock the nanoseconds-plus-fraction value grows by a programmable increment made of 4 whole and 16 fractional nanosecond bits. When the nanoseconds reach one billion, the seconds count goes up by one.

Software can correct a time offset without stepping the clock. It loads a cycle count, and for that many cycles a second, separate increment replaces the normal one, so the time runs slightly fast or slow until the count runs out. Software sets the time, the two increments and the count through a 32-bit word-addressed register port. Timestamp logic reads the live time from a single 96-bit output. The counter runs in the same clock domain as its consumers, nominally 156.25 MHz, and has an active-low reset.

Top module: `tod_clock`

## Requirements
- R1: After reset the seconds, nanoseconds, fraction, adjustment increment and adjustment count are zero. The normal increment reads back its nominal value: by default 6 ns plus 0x6666 sixty-five-thousand-five-hundred-thirty-sixths, which is 0x00066666 at offset 0x10.
- R2: When no time register is written, each clock edge adds the selected increment to {nanoseconds, fraction}. Any carry out of the fraction goes into the nanoseconds.
- R3: If the sum reaches or passes 1,000,000,000 ns, one billion is subtracted from it and the seconds count goes up by one on the same edge.
- R4: A write of N to the count register (offset 0x18, bits 19:0) takes effect on that edge. The next N edges use the adjustment increment and decrement the count by one each. After that the normal increment is used again. A read of 0x18 returns the remaining count.
- R5: Writing zero to the count register ends an adjustment window that is still running. From the next edge onward the normal increment is used.
- R6: A write to a time register loads that field directly. A nanoseconds write also clears the fraction. On the edge of any time-register write, the fields that are not written keep their values and no increment is applied.
- R7: Register layout. 0x00 holds seconds 47:32 in bits 15:0. 0x04 holds seconds 31:0. 0x08 holds the nanoseconds. 0x10 (normal increment) and 0x14 (adjustment increment) hold whole ns in bits 19:16 and fraction in bits 15:0. 0x18 holds the count in bits 19:0. Unused bits read as zero. Offset 0x0C and offsets above 0x18 read as zero, and writes to them have no effect.
- R8: Read data appears on the clock after a read strobe and shows the register values from the cycle of the strobe.
- R9: A read of 0x00 also captures the low seconds and the nanoseconds. The next read of 0x04 returns the captured low seconds and the next read of 0x08 returns the captured nanoseconds. Each captured value is returned once, and later reads return live values.
- R10: A write to an increment register takes effect on the edge after the write. The edge of the write itself still uses the old value.
- R11: The time output is {seconds[47:0], nanoseconds[31:0], fraction[15:0]}, 96 bits, taken straight from the counter registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the timestamp consumers |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 5 | Byte address; bits 1:0 are ignored |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| tod_stamp | output | 96 | Current time {seconds, nanoseconds, fraction} |

## Verification
A register write lands on the edge that samples it. A time write or a count write therefore shows on tod_stamp or in the count right after that edge. An increment change first affects the edge that follows. Read data becomes valid one edge after the strobe and shows the state from before that edge. The bench drives every strobe on a falling edge and compares on the next falling edge. For a read, it records the expected time from tod_stamp when it raises the strobe. For a run of increments, it counts exactly the rising edges that have passed since the last write.

// File: rtl/tod_pkg.sv
package tod_pkg;

  // word index = byte address >> 2
  typedef enum logic [2:0] {
    W_SEC_HI  = 3'd0,
    W_SEC_LO  = 3'd1,
    W_NSEC    = 3'd2,
    W_RSVD    = 3'd3,
    W_INC     = 3'd4,
    W_ADJ_INC = 3'd5,
    W_ADJ_CNT = 3'd6,
    W_NONE    = 3'd7
  } tod_word_e;

  localparam int unsigned NS_PER_SEC = 1_000_000_000;

  typedef struct packed {
    logic sec_hi;
    logic sec_lo;
    logic nsec;
  } tod_wr_t;

endpackage

// File: rtl/tod_adjust.sv
module tod_adjust #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] remain,
  output logic             active
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (load)
      cnt_q <= load_val;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign remain = cnt_q;
  assign active = (cnt_q != '0);

endmodule

// File: rtl/tod_accum.sv
module tod_accum #(
  parameter int SEC_W    = 48,
  parameter int NS_W     = 32,
  parameter int FRAC_W   = 16,
  parameter int INC_NS_W = 4,
  parameter int DATA_W   = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [INC_NS_W+FRAC_W-1:0]    inc,
  input  tod_pkg::tod_wr_t              wr,
  input  logic [DATA_W-1:0]             wdata,
  output logic [SEC_W-1:0]              sec,
  output logic [NS_W-1:0]               nsec,
  output logic [FRAC_W-1:0]             frac,
  output logic                          roll
);

  localparam int INC_W    = INC_NS_W + FRAC_W;
  localparam int ACC_W    = NS_W + FRAC_W + 1;
  localparam int SEC_HI_W = SEC_W - DATA_W;
  localparam logic [NS_W:0] WRAP = (NS_W+1)'(tod_pkg::NS_PER_SEC);

  // returns {wrapped, nsec, frac}
  function automatic logic [NS_W+FRAC_W:0] tod_step(
    input logic [NS_W-1:0]   ns_in,
    input logic [FRAC_W-1:0] fr_in,
    input logic [INC_W-1:0]  step
  );
    logic [ACC_W-1:0] sum;
    logic [NS_W:0]    whole;
    logic             wrapped;
    sum     = {1'b0, ns_in, fr_in} + ACC_W'(step);
    whole   = sum[ACC_W-1:FRAC_W];
    wrapped = (whole >= WRAP);
    if (wrapped)
      whole = whole - WRAP;
    return {wrapped, whole[NS_W-1:0], sum[FRAC_W-1:0]};
  endfunction

  logic [SEC_W-1:0]     sec_q;
  logic [NS_W-1:0]      ns_q;
  logic [FRAC_W-1:0]    frac_q;
  logic [NS_W+FRAC_W:0] nxt;
  logic                 any_wr;

  assign any_wr = wr.sec_hi | wr.sec_lo | wr.nsec;
  assign nxt    = tod_step(ns_q, frac_q, inc);
  assign roll   = !any_wr && nxt[NS_W+FRAC_W];

  generate
    if (SEC_HI_W > 0) begin : g_split_sec
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sec_q <= '0;
        end else if (any_wr) begin
          if (wr.sec_hi) sec_q[SEC_W-1:DATA_W] <= wdata[SEC_HI_W-1:0];
          if (wr.sec_lo) sec_q[DATA_W-1:0]     <= wdata;
        end else if (roll) begin
          sec_q <= sec_q + 1'b1;
        end
      end
    end else begin : g_single_sec
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          sec_q <= '0;
        else if (any_wr) begin
          if (wr.sec_lo) sec_q <= wdata[SEC_W-1:0];
        end else if (roll)
          sec_q <= sec_q + 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ns_q   <= '0;
      frac_q <= '0;
    end else if (any_wr) begin
      if (wr.nsec) begin
        ns_q   <= wdata[NS_W-1:0];
        frac_q <= '0;
      end
    end else begin
      ns_q   <= nxt[NS_W+FRAC_W-1:FRAC_W];
      frac_q <= nxt[FRAC_W-1:0];
    end
  end

  assign sec  = sec_q;
  assign nsec = ns_q;
  assign frac = frac_q;

endmodule

// File: rtl/tod_regs.sv
module tod_regs #(
  parameter int SEC_W    = 48,
  parameter int NS_W     = 32,
  parameter int INC_W    = 20,
  parameter int CNT_W    = 20,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 5,
  parameter logic [INC_W-1:0] INC_RESET = 20'h66666
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [SEC_W-1:0]     sec,
  input  logic [NS_W-1:0]      nsec,
  input  logic [CNT_W-1:0]     cnt_remain,
  output logic [INC_W-1:0]     inc_norm,
  output logic [INC_W-1:0]     inc_adj,
  output logic                 cnt_load,
  output logic [CNT_W-1:0]     cnt_val,
  output tod_pkg::tod_wr_t     time_wr,
  output logic [DATA_W-1:0]    rdata
);
  import tod_pkg::*;

  localparam int SEC_HI_W = SEC_W - DATA_W;

  tod_word_e          word;
  logic [INC_W-1:0]   inc_norm_q, inc_adj_q;
  logic [DATA_W-1:0]  snap_lo_q;
  logic [NS_W-1:0]    snap_ns_q;
  logic               snap_lo_vld, snap_ns_vld;
  logic [DATA_W-1:0]  rd_mux, rdata_q;

  assign word = (addr[ADDR_W-1:2] > (ADDR_W-2)'(W_NONE)) ? W_NONE
              : tod_word_e'(addr[4:2]);

  assign time_wr.sec_hi = wr_en && (word == W_SEC_HI);
  assign time_wr.sec_lo = wr_en && (word == W_SEC_LO);
  assign time_wr.nsec   = wr_en && (word == W_NSEC);
  assign cnt_load       = wr_en && (word == W_ADJ_CNT);
  assign cnt_val        = wdata[CNT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inc_norm_q <= INC_RESET;
      inc_adj_q  <= '0;
    end else if (wr_en) begin
      if (word == W_INC)     inc_norm_q <= wdata[INC_W-1:0];
      if (word == W_ADJ_INC) inc_adj_q  <= wdata[INC_W-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (word)
      W_SEC_HI:  rd_mux = DATA_W'(sec[SEC_W-1:DATA_W]);
      W_SEC_LO:  rd_mux = snap_lo_vld ? snap_lo_q : sec[DATA_W-1:0];
      W_NSEC:    rd_mux = DATA_W'(snap_ns_vld ? snap_ns_q : nsec);
      W_INC:     rd_mux = DATA_W'(inc_norm_q);
      W_ADJ_INC: rd_mux = DATA_W'(inc_adj_q);
      W_ADJ_CNT: rd_mux = DATA_W'(cnt_remain);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q     <= '0;
      snap_lo_q   <= '0;
      snap_ns_q   <= '0;
      snap_lo_vld <= 1'b0;
      snap_ns_vld <= 1'b0;
    end else if (rd_en) begin
      rdata_q <= rd_mux;
      if (word == W_SEC_HI) begin
        snap_lo_q   <= sec[DATA_W-1:0];
        snap_ns_q   <= nsec;
        snap_lo_vld <= 1'b1;
        snap_ns_vld <= 1'b1;
      end
      if (word == W_SEC_LO) snap_lo_vld <= 1'b0;
      if (word == W_NSEC)   snap_ns_vld <= 1'b0;
    end
  end

  assign inc_norm = inc_norm_q;
  assign inc_adj  = inc_adj_q;
  assign rdata    = rdata_q;

  if (SEC_HI_W <= 0) begin : g_bad_width
    initial $error("tod_regs: SEC_W must exceed DATA_W");
  end

endmodule

// File: rtl/tod_clock.sv
module tod_clock #(
  parameter int SEC_W     = 48,
  parameter int NS_W      = 32,
  parameter int FRAC_W    = 16,
  parameter int INC_NS_W  = 4,
  parameter int CNT_W     = 20,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 5,
  parameter int NOM_NS    = 6,
  parameter int NOM_FRAC  = 16'h6666,
  localparam int INC_W    = INC_NS_W + FRAC_W,
  localparam int STAMP_W  = SEC_W + NS_W + FRAC_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic [STAMP_W-1:0] tod_stamp
);

  localparam logic [INC_W-1:0] INC_RESET =
    {INC_NS_W'(NOM_NS), FRAC_W'(NOM_FRAC)};

  // named internal events, observed by the bound checker
  logic [SEC_W-1:0]  sec;
  logic [NS_W-1:0]   nsec;
  logic [FRAC_W-1:0] frac;
  logic [INC_W-1:0]  inc_norm, inc_adj, inc_sel;
  logic              cnt_load, adj_active, roll, time_wr_any;
  logic [CNT_W-1:0]  cnt_val, adj_remain;
  tod_pkg::tod_wr_t  time_wr;

  tod_regs #(
    .SEC_W(SEC_W), .NS_W(NS_W), .INC_W(INC_W), .CNT_W(CNT_W),
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .INC_RESET(INC_RESET)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .rd_en(reg_rd),
    .addr(reg_addr), .wdata(reg_wdata), .sec(sec), .nsec(nsec),
    .cnt_remain(adj_remain), .inc_norm(inc_norm), .inc_adj(inc_adj),
    .cnt_load(cnt_load), .cnt_val(cnt_val), .time_wr(time_wr),
    .rdata(reg_rdata)
  );

  tod_adjust #(.CNT_W(CNT_W)) u_adjust (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_val),
    .remain(adj_remain), .active(adj_active)
  );

  assign inc_sel     = adj_active ? inc_adj : inc_norm;
  assign time_wr_any = time_wr.sec_hi | time_wr.sec_lo | time_wr.nsec;

  tod_accum #(
    .SEC_W(SEC_W), .NS_W(NS_W), .FRAC_W(FRAC_W),
    .INC_NS_W(INC_NS_W), .DATA_W(DATA_W)
  ) u_accum (
    .clk(clk), .rst_n(rst_n), .inc(inc_sel), .wr(time_wr),
    .wdata(reg_wdata), .sec(sec), .nsec(nsec), .frac(frac), .roll(roll)
  );

  assign tod_stamp = {sec, nsec, frac};

endmodule

// File: rtl/tod_clock_chk.sv
module tod_clock_chk #(
  parameter int SEC_W  = 48,
  parameter int NS_W   = 32,
  parameter int FRAC_W = 16,
  parameter int INC_W  = 20,
  parameter int CNT_W  = 20,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [SEC_W-1:0]  sec,
  input logic [NS_W-1:0]   nsec,
  input logic [FRAC_W-1:0] frac,
  input logic [INC_W-1:0]  inc_norm,
  input logic [INC_W-1:0]  inc_adj,
  input logic              adj_active,
  input logic [CNT_W-1:0]  adj_remain,
  input logic              cnt_load,
  input logic              time_wr_any,
  input logic              roll
);
  localparam int NF_W = NS_W + FRAC_W;
  localparam logic [NS_W-1:0] WRAP = NS_W'(tod_pkg::NS_PER_SEC);

  logic [NF_W-1:0]  nf_now;
  logic [INC_W-1:0] inc_used;
  logic             rd_sec_hi, wr_nsec;
  assign nf_now    = {nsec, frac};
  assign inc_used  = adj_active ? inc_adj : inc_norm;
  assign rd_sec_hi = reg_rd && (reg_addr[ADDR_W-1:2] == '0);
  assign wr_nsec   = reg_wr && (reg_addr[ADDR_W-1:2] == (ADDR_W-2)'(2));

  assert_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!time_wr_any && !roll) |=> nf_now == $past(nf_now) + NF_W'($past(inc_used)));

  assert_ns_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!time_wr_any && nsec < WRAP) |=> nsec < WRAP);

  assert_sec_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!time_wr_any && roll) |=> sec == $past(sec) + 1'b1);

  assert_sec_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!time_wr_any && !roll) |=> $stable(sec));

  assert_count_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_load && adj_remain != '0) |=> adj_remain == $past(adj_remain) - 1'b1);

  assert_count_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_load && adj_remain == '0) |=> adj_remain == '0);

  assert_ns_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_nsec |=> (frac == '0) && (nsec == $past(reg_wdata[NS_W-1:0])));

  assert_hi_unused_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sec_hi |=> reg_rdata[DATA_W-1:SEC_W-DATA_W] == '0);

endmodule

bind tod_clock tod_clock_chk #(
  .SEC_W(SEC_W), .NS_W(NS_W), .FRAC_W(FRAC_W), .INC_W(INC_W),
  .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .sec(sec), .nsec(nsec), .frac(frac), .inc_norm(inc_norm),
  .inc_adj(inc_adj), .adj_active(adj_active), .adj_remain(adj_remain),
  .cnt_load(cnt_load), .time_wr_any(time_wr_any), .roll(roll)
);

// File: tb/test_tod_clock.sv
module test_tod_clock;
  localparam int CLK_PERIOD = 10;

  localparam logic [4:0] A_SEC_HI = 5'h00, A_SEC_LO = 5'h04, A_NSEC = 5'h08,
                         A_RSVD = 5'h0C, A_INC = 5'h10, A_ADJ_INC = 5'h14,
                         A_ADJ_CNT = 5'h18;

  typedef struct packed {
    logic [19:0] inc;
    logic [31:0] start_ns;
    logic [7:0]  edges;
    logic [47:0] exp_sec;
    logic [31:0] exp_ns;
    logic [15:0] exp_frac;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{20'h80000, 32'd0,         8'd10, 48'd0, 32'd80,  16'h0000},
    '{20'h66666, 32'd0,         8'd5,  48'd0, 32'd31,  16'hFFFE},
    '{20'h08000, 32'd100,       8'd3,  48'd0, 32'd101, 16'h8000},
    '{20'h80000, 32'd999999990, 8'd2,  48'd1, 32'd6,   16'h0000},
    '{20'hFFFFF, 32'd999999999, 8'd1,  48'd1, 32'd14,  16'hFFFF},
    '{20'h00000, 32'd12345,     8'd4,  48'd0, 32'd12345, 16'h0000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [95:0] tod_stamp;

  int n_cmp = 0, n_bad = 0;

  tod_clock i_tod_clock (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tod_stamp(tod_stamp)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [95:0] act, input logic [95:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  function automatic logic [31:0] ns_of(input logic [95:0] s);
    return s[47:16];
  endfunction

  initial begin
    #(CLK_PERIOD*50000);
    n_bad++;
    $display("FAIL watchdog (all R): actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [95:0] s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    check("R1 stamp", tod_stamp, '0);
    rd(A_INC, d);     check("R1 nominal increment", 96'(d), 96'h66666);
    rd(A_ADJ_INC, d); check("R1 adjust increment", 96'(d), '0);
    rd(A_ADJ_CNT, d); check("R1 adjust count", 96'(d), '0);

    // R7: masks, reserved word
    wr(A_INC, 32'hFFFF_FFFF);     rd(A_INC, d);     check("R7 increment mask", 96'(d), 96'h000FFFFF);
    wr(A_ADJ_INC, 32'hFFFF_FFFF); rd(A_ADJ_INC, d); check("R7 adj increment mask", 96'(d), 96'h000FFFFF);
    wr(A_RSVD, 32'hFFFF_FFFF);    rd(A_RSVD, d);    check("R7 reserved reads zero", 96'(d), '0);
    wr(A_ADJ_CNT, 32'hFFFF_FFFF); rd(A_ADJ_CNT, d); check("R7 count mask", 96'(d), 96'h000FFFFF);
    wr(A_ADJ_CNT, 32'h0);

    // R2 R3 R11: vector table
    foreach (VECS[i]) begin
      wr(A_INC, 32'(VECS[i].inc));
      wr(A_SEC_HI, 32'h0);
      wr(A_SEC_LO, 32'h0);
      wr(A_NSEC, VECS[i].start_ns);
      repeat (VECS[i].edges) @(negedge clk);
      check($sformatf("R2/R3/R11 vector %0d", i), tod_stamp,
            {VECS[i].exp_sec, VECS[i].exp_ns, VECS[i].exp_frac});
    end

    // R10: increment change delayed by one edge
    wr(A_INC, 32'h80000);
    wr(A_NSEC, 32'd0);
    wr(A_INC, 32'h30000);
    repeat (2) @(negedge clk);
    check("R10 old increment on write edge", 96'(ns_of(tod_stamp)), 96'd14);

    // R6: time writes hold the other fields
    s = tod_stamp;
    wr(A_SEC_LO, 32'd7);
    check("R6 seconds write freezes ns", tod_stamp, {s[95:80], 32'd7, s[47:0]});
    wr(A_NSEC, 32'd500);
    check("R6 ns write clears fraction", tod_stamp, {s[95:80], 32'd7, 32'd500, 16'h0});

    // R8: read latency and value timing
    s = tod_stamp;
    rd(A_NSEC, d);
    check("R8 read shows strobe-cycle value", 96'(d), 96'(ns_of(s)));

    // R4: adjustment window
    wr(A_INC, 32'h80000);
    wr(A_ADJ_INC, 32'hA0000);
    wr(A_SEC_HI, 32'h0);
    wr(A_SEC_LO, 32'h0);
    wr(A_NSEC, 32'd0);
    wr(A_ADJ_CNT, 32'd3);
    check("R4 count write edge uses normal", 96'(ns_of(tod_stamp)), 96'd8);
    rd(A_ADJ_CNT, d);
    check("R4 remaining count", 96'(d), 96'd3);
    repeat (2) @(negedge clk);
    check("R4 adjust increment applied", 96'(ns_of(tod_stamp)), 96'd38);
    repeat (2) @(negedge clk);
    check("R4 normal increment resumes", 96'(ns_of(tod_stamp)), 96'd54);

    // R5: cancel with zero
    wr(A_ADJ_CNT, 32'd100);
    repeat (2) @(negedge clk);
    wr(A_ADJ_CNT, 32'd0);
    repeat (2) @(negedge clk);
    check("R5 cancel restores normal", 96'(ns_of(tod_stamp)), 96'd108);
    rd(A_ADJ_CNT, d);
    check("R5 count reads zero", 96'(d), '0);

    // R9: coherent multi-word read across a seconds rollover
    wr(A_SEC_HI, 32'h0001);
    wr(A_SEC_LO, 32'hFFFF_FFFF);
    wr(A_NSEC, 32'd999999992);
    rd(A_SEC_HI, d);
    check("R9/R7 high seconds", 96'(d), 96'h0001);
    check("R3 rollover into high word", tod_stamp, {48'h2_0000_0000, 32'd0, 16'h0});
    rd(A_SEC_LO, d);
    check("R9 captured low seconds", 96'(d), 96'hFFFF_FFFF);
    rd(A_NSEC, d);
    check("R9 captured ns", 96'(d), 96'd999999992);
    rd(A_SEC_LO, d);
    check("R9 live after capture used", 96'(d), '0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule